// File: doc/BRIEF.md
# Prescaled Reference Compare Timer

A 16-bit up-counting timer driven by a programmable divider on the system clock. Software programs a control word that holds an enable bit, a tick-source field, a wrap-on-match bit, an interrupt-enable bit and an 8-bit divider value. The counter advances by one on each divided tick. When a tick arrives while the count equals the reference value, a sticky match flag is raised. In wrap mode the counter then returns to zero; otherwise it keeps counting. The interrupt line follows the match flag while the interrupt enable is set.

Registers are reached through a synchronous write port and a combinational read port, both selected by a byte offset. The match flag is cleared by writing a one to it. Clearing the enable bit while it is set also wipes the reference value. Any write to the control word or the reference value restarts the divider phase, so a new divisor applies from a known point. The capture word is plain storage. Capture, output-pin and external-clock behaviour are not modelled.

Top module: `ref_cmp_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The control word (offset 0x00), reference (0x04) and capture (0x08) registers read back exactly what was last written. The capture word has no other effect.
- R3: With control bits 2:1 = 1 the divider ticks every (P+1) clocks, and with bits 2:1 = 2 every 16*(P+1) clocks, where P is control bits 15:8. The match flag is set (R+1) ticks after the control write that enables the timer from a count of zero, where R is the reference value.
- R4: The counter (offset 0x0C) does not change while control bit 0 is 0, or while control bits 2:1 are 0 or 3.
- R5: When control bit 3 is 1, a tick at count == reference sets the counter to 0. When it is 0, the counter goes on to reference+1.
- R6: The event word (offset 0x11) has the match flag in bit 1 and the capture flag in bit 0. Writing it clears each bit written as 1 and leaves the bits written as 0.
- R7: `irq` is high exactly when control bit 4 and the match flag are both 1.
- R8: A control write that changes bit 0 from 1 to 0 stores the written value and clears the reference to zero. Other control writes leave the reference unchanged.
- R9: Writing the counter offset loads the count directly, and the loaded value wins over a tick in the same cycle.
- R10: Offsets other than 0x00, 0x04, 0x08, 0x0C and 0x11 read as zero, and writes to them change no register.
- R11: A write to the reference register restarts the divider phase, so the next tick comes a full divisor after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | ADDR_W | Byte offset for read and write |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| irq | output | 1 | Match interrupt request |

## Verification
Register writes take effect at the rising edge that samples `wr_en`, and reads are combinational, so the bench drives on the falling edge and reads a short delay after it. A match flag appears exactly (R+1)*D rising edges after the enabling control write, where D is the divisor. For each swept combination the bench therefore waits (R+1)*D-1 edges, confirms the flag is still clear, and then confirms it is set one edge later. `irq` and the wrapped count are checked in that same sampling slot. Counter loads are checked in the half cycle right after the write edge, and again one edge later to see the increment.

// File: rtl/rct_pkg.sv
// Shared offsets, bit positions and tick-source encoding for the timer.
package rct_pkg;
    localparam int OFF_CTRL = 'h00;
    localparam int OFF_REF  = 'h04;
    localparam int OFF_CAPT = 'h08;
    localparam int OFF_CNT  = 'h0C;
    localparam int OFF_EVT  = 'h11;

    localparam int CB_EN     = 0;
    localparam int CB_SRC_LO = 1;
    localparam int CB_WRAP   = 3;
    localparam int CB_IRQEN  = 4;
    localparam int CB_DIV_LO = 8;

    localparam int EB_CAPT = 0;
    localparam int EB_MATCH = 1;
    localparam int EVT_W   = 2;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_DIV   = 2'd1,
        SRC_DIV16 = 2'd2,
        SRC_EXT   = 2'd3
    } tick_src_e;
endpackage

// File: rtl/rct_regs.sv
// Register file: decodes offsets, holds control, reference, capture and event
// words, and forms the read mux. Assumes at most one write per cycle and that
// all offsets fit in ADDR_W bits.
module rct_regs
    import rct_pkg::*;
#(
    parameter int DW     = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     count_q,
    input  logic              ref_hit,
    output logic [DW-1:0]     rdata,
    output logic              run_en,
    output tick_src_e         src,
    output logic              wrap_mode,
    output logic              irq_en,
    output logic [DW-9:0]     div_val,
    output logic [DW-1:0]     ref_q,
    output logic              match_flag,
    output logic              cnt_load,
    output logic              phase_clr
);
    logic [DW-1:0]    ctrl_q;
    logic [DW-1:0]    capt_q;
    logic [EVT_W-1:0] evt_q;
    logic sel_ctrl, sel_ref, sel_capt, sel_cnt, sel_evt;
    logic wr_ctrl, wr_ref, wr_capt, wr_evt, shut_off;
    logic [EVT_W-1:0] evt_clr, evt_set;

    // Offset decode.
    always_comb begin
        sel_ctrl = (addr == ADDR_W'(OFF_CTRL));
        sel_ref  = (addr == ADDR_W'(OFF_REF));
        sel_capt = (addr == ADDR_W'(OFF_CAPT));
        sel_cnt  = (addr == ADDR_W'(OFF_CNT));
        sel_evt  = (addr == ADDR_W'(OFF_EVT));
    end

    // Write strobes and the enable 1->0 detection.
    always_comb begin
        wr_ctrl  = wr_en & sel_ctrl;
        wr_ref   = wr_en & sel_ref;
        wr_capt  = wr_en & sel_capt;
        wr_evt   = wr_en & sel_evt;
        cnt_load = wr_en & sel_cnt;
        shut_off = wr_ctrl & ctrl_q[CB_EN] & ~wdata[CB_EN];
        phase_clr = wr_ctrl | wr_ref;
    end

    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wdata;
    end

    // Reference storage, wiped when the timer is switched off.
    always_ff @(posedge clk) begin
        if (!rst_n)        ref_q <= '0;
        else if (shut_off) ref_q <= '0;
        else if (wr_ref)   ref_q <= wdata;
    end

    // Capture word, plain storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       capt_q <= '0;
        else if (wr_capt) capt_q <= wdata;
    end

    // Event flag set and write-one-to-clear terms; a set wins over a clear.
    always_comb begin
        evt_clr = wr_evt ? wdata[EVT_W-1:0] : '0;
        evt_set = '0;
        evt_set[EB_MATCH] = ref_hit;
    end

    // Event word update.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (evt_q & ~evt_clr) | evt_set;
    end

    // Field extraction for the datapath.
    always_comb begin
        run_en     = ctrl_q[CB_EN];
        src        = tick_src_e'(ctrl_q[CB_SRC_LO +: 2]);
        wrap_mode  = ctrl_q[CB_WRAP];
        irq_en     = ctrl_q[CB_IRQEN];
        div_val    = ctrl_q[DW-1:CB_DIV_LO];
        match_flag = evt_q[EB_MATCH];
    end

    // Read mux; unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        if (sel_ctrl)      rdata = ctrl_q;
        else if (sel_ref)  rdata = ref_q;
        else if (sel_capt) rdata = capt_q;
        else if (sel_cnt)  rdata = count_q;
        else if (sel_evt)  rdata = DW'(evt_q);
    end
endmodule

// File: rtl/rct_prescaler.sv
// Clock divider: emits a one-cycle tick every (div_val+1) clocks, or 16 times
// that when the divide-by-16 source is chosen. Holds at phase zero while not
// running or when phase_clr is asserted.
module rct_prescaler
    import rct_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int EXT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  tick_src_e        src,
    input  logic [PRE_W-1:0] div_val,
    input  logic             phase_clr,
    output logic             tick
);
    localparam int CW = PRE_W + EXT_W + 1;

    logic [CW-1:0] phase_q;
    logic [CW-1:0] base, term;
    logic          active;

    // Terminal phase from the divider value and source.
    always_comb begin
        base   = CW'(div_val) + CW'(1);
        term   = ((src == SRC_DIV16) ? (base << EXT_W) : base) - CW'(1);
        active = run_en & ((src == SRC_DIV) | (src == SRC_DIV16));
        tick   = active & (phase_q == term);
    end

    // Phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                         phase_q <= '0;
        else if (!active || phase_clr || tick) phase_q <= '0;
        else                                phase_q <= phase_q + CW'(1);
    end
endmodule

// File: rtl/rct_counter.sv
// Up-counter with reference compare. A tick at count == reference raises
// ref_hit; in wrap mode the count then returns to zero. A direct load wins.
module rct_counter #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wrap_mode,
    input  logic [DW-1:0] ref_val,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] count_q,
    output logic          ref_hit
);
    // Compare on tick.
    always_comb ref_hit = tick & (count_q == ref_val);

    // Count, wrap or load.
    always_ff @(posedge clk) begin
        if (!rst_n)                     count_q <= '0;
        else if (load)                  count_q <= load_val;
        else if (ref_hit && wrap_mode)  count_q <= '0;
        else if (tick)                  count_q <= count_q + DW'(1);
    end
endmodule

// File: rtl/ref_cmp_timer.sv
// Top of the prescaled reference compare timer: register file, divider and
// compare counter. Assumes DW >= 16 so the divider field is DW-8 bits wide.
module ref_cmp_timer
    import rct_pkg::*;
#(
    parameter int DW     = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              irq
);
    localparam int PRE_W = DW - 8;

    logic             run_en, wrap_mode, irq_en, match_flag;
    logic             cnt_load, phase_clr, tick, ref_hit;
    tick_src_e        src;
    logic [PRE_W-1:0] div_val;
    logic [DW-1:0]    ref_q, count_q;

    rct_regs #(.DW(DW), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .count_q(count_q), .ref_hit(ref_hit), .rdata(rdata),
        .run_en(run_en), .src(src), .wrap_mode(wrap_mode), .irq_en(irq_en),
        .div_val(div_val), .ref_q(ref_q), .match_flag(match_flag),
        .cnt_load(cnt_load), .phase_clr(phase_clr)
    );

    rct_prescaler #(.PRE_W(PRE_W), .EXT_W(4)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .src(src),
        .div_val(div_val), .phase_clr(phase_clr), .tick(tick)
    );

    rct_counter #(.DW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wrap_mode(wrap_mode),
        .ref_val(ref_q), .load(cnt_load), .load_val(wdata),
        .count_q(count_q), .ref_hit(ref_hit)
    );

    // Interrupt request from the stored flag and enable.
    always_comb irq = irq_en & match_flag;
endmodule

// File: rtl/rct_checker.sv
// Temporal checks on the timer, attached to every instance through bind.
module rct_checker
    import rct_pkg::*;
#(
    parameter int DW     = 16,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              wd_b0,
    input logic              wd_b1,
    input logic              run_en,
    input logic              wrap_mode,
    input logic              match_flag,
    input logic              irq,
    input logic              tick,
    input logic              ref_hit,
    input logic              cnt_load,
    input logic [DW-1:0]     count_q,
    input logic [DW-1:0]     ref_q
);
    logic evt_w1c, ctrl_wr;
    always_comb begin
        evt_w1c = wr_en & (addr == ADDR_W'(OFF_EVT)) & wd_b1;
        ctrl_wr = wr_en & (addr == ADDR_W'(OFF_CTRL));
    end

    assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !cnt_load) |=> $stable(count_q));
    assert_tick_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run_en);
    assert_hit_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_hit |=> match_flag);
    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_w1c && !ref_hit) |=> !match_flag);
    assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_hit && wrap_mode && !cnt_load) |=> (count_q == '0));
    assert_shutoff_clears_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && run_en && !wd_b0) |=> (ref_q == '0));
    assert_irq_drops_on_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_w1c && !ref_hit) |=> !irq);
endmodule

bind ref_cmp_timer rct_checker #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wd_b0(wdata[0]), .wd_b1(wdata[1]), .run_en(run_en),
    .wrap_mode(wrap_mode), .match_flag(match_flag), .irq(irq), .tick(tick),
    .ref_hit(ref_hit), .cnt_load(cnt_load), .count_q(count_q), .ref_q(ref_q)
);

// File: tb/ref_cmp_timer_bench.sv
`timescale 1ns/1ps
module ref_cmp_timer_bench;
    localparam int DW = 16;
    localparam int AW = 5;
    localparam logic [AW-1:0] A_CTRL = 5'h00, A_REF = 5'h04, A_CAPT = 5'h08,
                              A_CNT = 5'h0C, A_EVT = 5'h11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;
    int checks = 0;
    int errors = 0;

    ref_cmp_timer #(.DW(DW), .ADDR_W(AW)) u_ref_cmp_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #0.2 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        addr = a;
        #0.2 d = rdata;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd(A_REF, v);  chk("R1 ref", v, 0);
        rd(A_CAPT, v); chk("R1 capt", v, 0);
        rd(A_CNT, v);  chk("R1 cnt", v, 0);
        rd(A_EVT, v);  chk("R1 evt", v, 0);
        chk("R1 irq", 16'(irq), 0);

        // R2: readback of storage registers
        wr(A_CTRL, 16'hAB30); wr(A_REF, 16'h5A5A); wr(A_CAPT, 16'hC3C3);
        @(negedge clk);
        rd(A_CTRL, v); chk("R2 ctrl", v, 16'hAB30);
        rd(A_REF, v);  chk("R2 ref", v, 16'h5A5A);
        rd(A_CAPT, v); chk("R2 capt", v, 16'hC3C3);

        // R10: unmapped offsets read zero, writes ignored
        for (int a = 0; a < 32; a++)
            if (!(a inside {0, 4, 8, 12, 17})) wr(AW'(a), 16'hFFFF);
        @(negedge clk);
        for (int a = 0; a < 32; a++)
            if (!(a inside {0, 4, 8, 12, 17})) begin
                rd(AW'(a), v); chk("R10 unmapped read", v, 0);
            end
        rd(A_CTRL, v); chk("R10 ctrl untouched", v, 16'hAB30);
        rd(A_REF, v);  chk("R10 ref untouched", v, 16'h5A5A);
        rd(A_CAPT, v); chk("R10 capt untouched", v, 16'hC3C3);
        rd(A_CNT, v);  chk("R10 cnt untouched", v, 0);
        rd(A_EVT, v);  chk("R10 evt untouched", v, 0);

        // R3/R5/R7: divisor and period sweep in wrap mode with irq enabled
        for (int p = 0; p < 3; p++)
            for (int s = 1; s < 3; s++)
                for (int r = 0; r < 4; r++) begin
                    int d, n;
                    d = (p + 1) * ((s == 2) ? 16 : 1);
                    n = (r + 1) * d;
                    wr(A_CTRL, 16'h0000);
                    wr(A_CNT, 16'h0000);
                    wr(A_EVT, 16'h0003);
                    wr(A_REF, 16'(r));
                    wr(A_CTRL, 16'((p << 8) | (s << 1) | 16'h0019));
                    repeat (n - 1) @(posedge clk);
                    @(negedge clk);
                    rd(A_EVT, v); chk("R3 flag not early", v, 0);
                    chk("R7 irq low before match", 16'(irq), 0);
                    @(posedge clk); @(negedge clk);
                    rd(A_EVT, v); chk("R3 flag on time", v, 16'h0002);
                    chk("R7 irq high on match", 16'(irq), 1);
                    rd(A_CNT, v); chk("R5 wrap to zero", v, 0);
                end

        // R6: write-one-to-clear on the event word
        wr(A_CTRL, 16'h0000);
        @(negedge clk);
        rd(A_EVT, v); chk("R6 flag held when stopped", v, 16'h0002);
        wr(A_EVT, 16'h0001);
        @(negedge clk); rd(A_EVT, v); chk("R6 capture-bit write keeps match", v, 16'h0002);
        wr(A_EVT, 16'h0000);
        @(negedge clk); rd(A_EVT, v); chk("R6 zero write keeps match", v, 16'h0002);
        wr(A_EVT, 16'h0002);
        @(negedge clk); rd(A_EVT, v); chk("R6 match cleared", v, 0);

        // R5/R7: free-running, irq disabled
        wr(A_CNT, 16'h0000); wr(A_REF, 16'h0002);
        wr(A_CTRL, 16'h0003);
        repeat (2) @(posedge clk);
        @(negedge clk); rd(A_EVT, v); chk("R3 free-run not early", v, 0);
        @(posedge clk); @(negedge clk);
        rd(A_EVT, v); chk("R5 free-run flag", v, 16'h0002);
        chk("R7 irq low when disabled", 16'(irq), 0);
        rd(A_CNT, v); chk("R5 count passes reference", v, 16'h0003);

        // R9: direct load wins over a tick, then counting resumes
        wr(A_REF, 16'hFFFF); wr(A_CTRL, 16'h0003);
        wr(A_CNT, 16'h0040);
        @(negedge clk); rd(A_CNT, v); chk("R9 load value", v, 16'h0040);
        @(negedge clk); rd(A_CNT, v); chk("R9 count after load", v, 16'h0041);

        // R4: no counting when disabled or source 0 / 3
        wr(A_CTRL, 16'h0000); wr(A_CNT, 16'h0007);
        repeat (40) @(posedge clk);
        @(negedge clk); rd(A_CNT, v); chk("R4 disabled hold", v, 16'h0007);
        wr(A_CTRL, 16'h0001);
        repeat (40) @(posedge clk);
        @(negedge clk); rd(A_CNT, v); chk("R4 source 0 hold", v, 16'h0007);
        wr(A_CTRL, 16'h0007);
        repeat (40) @(posedge clk);
        @(negedge clk); rd(A_CNT, v); chk("R4 source 3 hold", v, 16'h0007);

        // R8: switching off clears the reference; other writes keep it
        wr(A_CTRL, 16'h0001); wr(A_REF, 16'h1234);
        wr(A_CTRL, 16'hAB30);
        @(negedge clk);
        rd(A_CTRL, v); chk("R8 ctrl takes written value", v, 16'hAB30);
        rd(A_REF, v);  chk("R8 ref cleared on shut-off", v, 0);
        wr(A_REF, 16'h0055); wr(A_CTRL, 16'h0030);
        @(negedge clk); rd(A_REF, v); chk("R8 off-to-off keeps ref", v, 16'h0055);
        wr(A_CTRL, 16'h0001); wr(A_CTRL, 16'h0101);
        @(negedge clk); rd(A_REF, v); chk("R8 on-to-on keeps ref", v, 16'h0055);

        // R11: reference write restarts divider phase (divisor 4)
        wr(A_CTRL, 16'h0000); wr(A_CNT, 16'h0000); wr(A_EVT, 16'h0003);
        wr(A_REF, 16'h0064);
        wr(A_CTRL, 16'h030B);
        repeat (2) @(posedge clk);
        wr(A_REF, 16'h0001);
        repeat (7) @(posedge clk);
        @(negedge clk); rd(A_EVT, v); chk("R11 no match before restarted phase", v, 0);
        @(posedge clk); @(negedge clk);
        rd(A_EVT, v); chk("R11 match after restarted phase", v, 16'h0002);

        // R9: load while running with a long divisor
        wr(A_CTRL, 16'hFF05);
        wr(A_CNT, 16'h0100);
        repeat (3) @(posedge clk);
        @(negedge clk); rd(A_CNT, v); chk("R9 load under slow divider", v, 16'h0100);

        summary();
    end
endmodule